// File: doc/BRIEF.md
# Decimating ADC Capture Channel

This block is one acquisition channel for a serial analog-to-digital converter. Bits arrive one per bit-clock strobe, most significant bit first. They are packed into 16-bit signed samples, so sixteen strobes give one sample. The raw stream feeds a chain of two filter-and-downsample stages, each reducing the rate by eight. A runtime rate code picks which of the three streams (raw, divided by 8, divided by 64) is stored.

Storage is a ping-pong memory of two equal banks. Nothing is written until a trigger input has been seen. When a bank fills, writing moves to the other bank and the interrupt line rises. At the same time the free-running 64-bit cycle counter is latched as that bank's timestamp. A processor then reads the finished bank and its timestamp through a registered read port while the other bank fills. It acknowledges the interrupt by writing the control word.

The rate code is sampled only while the channel is idle and at each bank boundary, so a bank never mixes sample rates.

Top module: `adc_decim_capture`

## Requirements
- R1: Serial bits are taken on cycles with `bit_en` high. A bit with `ser_sync` high is the most significant bit of a new sample, and the sixteenth bit completes the sample. With rate code 0 every completed sample is stored unchanged.
- R2: With rate code 1 each stored word is the filtered value of one block of eight consecutive raw samples. The filter sums the samples weighted 1,3,5,7,7,5,3,1, shifts the sum arithmetically right by 5 (rounding toward minus infinity) and saturates the result to 16-bit signed. Blocks start at the first sample after reset.
- R3: With rate code 2 (code 3 behaves the same) each stored word is the same filter applied to eight consecutive outputs of the first stage, one stored word per 64 raw samples.
- R4: A constant input reaches the output of a stage unchanged, because the DC gain is unity. A full-scale positive input stays 16'h7FFF.
- R5: Samples completed before `trig` is seen high are not stored. The first sample strobe after the cycle in which `trig` is high goes to word 0 of bank 0.
- R6: Bank 0 fills first, at data addresses 0 to N-1; bank 1 lies at N to 2N-1. When word N-1 of a bank is written, writing continues at word 0 of the other bank, `irq` rises, and status bit 2 gives the bank just completed.
- R7: A 64-bit counter advances every clock from reset. Its value at the moment a bank completes is latched for that bank. Bank 0's timestamp reads at register words 4..7 and bank 1's at 8..11, least significant 16 bits first.
- R8: `irq` (status bit 0) stays high until control word 0 is written with bit 0 set. A bank completing while `irq` is still high sets the overrun flag (status bit 1), which is cleared by writing bit 1.
- R9: A change of `rate_sel` while capturing takes effect only for the bank that starts after the next completion. Status bits 4:3 show the rate code in force.
- R10: Read addresses with the top bit clear return buffer words; with the top bit set they return register words (0 status, 4..11 timestamps, others zero). Read data appears one clock after the address. After reset, status reads zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit strobe: a serial bit is present this cycle |
| ser_bit | input | 1 | Serial data bit from the converter |
| ser_sync | input | 1 | Marks the most significant bit of a sample |
| trig | input | 1 | Capture start trigger |
| rate_sel | input | 2 | 0 raw, 1 divide by 8, 2 or 3 divide by 64 |
| rd_addr | input | AW (10 by default) | Read address; top bit selects register space |
| rd_data | output | 16 | Read data, one clock after the address |
| wr_en | input | 1 | Write strobe for the control word |
| wr_addr | input | AW (10 by default) | Write address; control word is register word 0 |
| wr_data | input | 2 | Bit 0 clears the interrupt, bit 1 clears overrun |
| irq | output | 1 | Level interrupt: a bank is ready |

## Verification
The hardest situation to reach from the ports is a rate change that lands mid-bank. The bench must show that the old rate continues to the boundary and that the first word of the next bank is the correct decimated output. Getting there needs a full bank of raw samples with `rate_sel` moved after the fourth sample. The bench computes which first-stage block finishes right after the boundary, which is block 1, because the bank ends exactly on an eight-sample boundary. The divide-by-64 path and the overrun case also need long runs, so the bench uses 16-word banks. It streams 1024 pseudo-random samples, or two back-to-back banks without an acknowledge.

// File: rtl/adcch_pkg.sv
package adcch_pkg;

  localparam int SAMPLE_W = 16;

  // Weight of tap idx in a symmetric triangular kernel of ntaps (odd weights).
  // For ntaps a power of two the weights sum to ntaps*ntaps/2.
  function automatic int tap_weight(input int idx, input int ntaps);
    int m;
    m = (idx < ntaps - 1 - idx) ? idx : ntaps - 1 - idx;
    return 2 * m + 1;
  endfunction

  // Clamp a wide signed value into the 16-bit signed range.
  function automatic logic [SAMPLE_W-1:0] clip_sample(input logic signed [31:0] v);
    if (v > 32'sd32767) return 16'h7FFF;
    if (v < -32'sd32768) return 16'h8000;
    return v[SAMPLE_W-1:0];
  endfunction

endpackage

// File: rtl/adcch_deser.sv
module adcch_deser #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         bit_in,
  input  logic         sync,
  output logic         word_valid,
  output logic [W-1:0] word_data
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh_q, sh_nxt, word_q;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          vld_q;

  always_comb begin
    sh_nxt  = sync ? {{(W-1){1'b0}}, bit_in} : {sh_q[W-2:0], bit_in};
    cnt_nxt = sync ? CW'(1) : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      vld_q <= 1'b0;
      if (bit_en) begin
        if (cnt_nxt == CW'(W)) begin
          vld_q  <= 1'b1;
          word_q <= sh_nxt;
          cnt_q  <= '0;
          sh_q   <= '0;
        end else begin
          sh_q  <= sh_nxt;
          cnt_q <= cnt_nxt;
        end
      end
    end
  end

  assign word_valid = vld_q;
  assign word_data  = word_q;

  // R1
  word_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R1
  word_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(bit_en));

endmodule

// File: rtl/adcch_decim.sv
module adcch_decim
  import adcch_pkg::*;
#(
  parameter int DEC = 8,   // power of two
  parameter int W   = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int PW    = $clog2(DEC);
  localparam int SHIFT = 2 * PW - 1;   // weights sum to 2**SHIFT

  logic [DEC-1:0][W-1:0] win_q;
  logic [PW-1:0]         phase_q;
  logic                  fire_q;

  function automatic logic signed [31:0] weighted_sum(input logic [DEC-1:0][W-1:0] w);
    logic signed [31:0] acc;
    acc = '0;
    for (int i = 0; i < DEC; i++)
      acc = acc + 32'($signed(w[i])) * tap_weight(i, DEC);
    return acc;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q   <= '0;
      phase_q <= '0;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= in_valid && (phase_q == PW'(DEC - 1));
      if (in_valid) begin
        win_q   <= {win_q[DEC-2:0], in_data};
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign out_valid = fire_q;
  assign out_data  = clip_sample(weighted_sum(win_q) >>> SHIFT);

  // R2
  out_follows_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R2
  out_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

endmodule

// File: rtl/adcch_pingpong.sv
module adcch_pingpong #(
  parameter int WORDS = 256,
  parameter int W     = 16,
  parameter int TSW   = 64,   // four read words of W
  parameter int SELW  = 2,
  parameter int AW    = $clog2(2 * WORDS) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic [SELW-1:0] rate_sel,
  output logic [SELW-1:0] active_sel,
  input  logic            samp_valid,
  input  logic [W-1:0]    samp_data,
  input  logic [TSW-1:0]  tstamp,
  input  logic [AW-1:0]   rd_addr,
  output logic [W-1:0]    rd_data,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [1:0]      wr_data,
  output logic            irq
);
  localparam int PTRW = $clog2(WORDS);
  localparam int IDXW = AW - 1;

  logic [W-1:0]          mem [2*WORDS];
  logic [1:0][TSW-1:0]   ts_q;
  logic [PTRW-1:0]       wptr_q;
  logic                  running_q, bank_q, done_q, irq_q, ovr_q;
  logic [SELW-1:0]       sel_q;
  logic [W-1:0]          rd_q, reg_word;
  logic [IDXW-1:0]       reg_idx;

  // Named events for the checks below.
  logic store, bank_done, ctl_hit, irq_clr, ovr_clr;

  assign store     = running_q && samp_valid;
  assign bank_done = store && (wptr_q == PTRW'(WORDS - 1));
  assign ctl_hit   = wr_en && wr_addr[AW-1] && (wr_addr[IDXW-1:0] == '0);
  assign irq_clr   = ctl_hit && wr_data[0];
  assign ovr_clr   = ctl_hit && wr_data[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      bank_q    <= 1'b0;
      done_q    <= 1'b0;
      wptr_q    <= '0;
      irq_q     <= 1'b0;
      ovr_q     <= 1'b0;
      sel_q     <= '0;
      ts_q      <= '0;
    end else begin
      if (!running_q) begin
        sel_q <= rate_sel;
        if (trig) running_q <= 1'b1;
      end
      if (store) wptr_q <= bank_done ? '0 : wptr_q + 1'b1;
      if (bank_done) begin
        bank_q         <= ~bank_q;
        done_q         <= bank_q;
        ts_q[bank_q]   <= tstamp;
        sel_q          <= rate_sel;
      end
      if (bank_done)    irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
      if (bank_done && irq_q) ovr_q <= 1'b1;
      else if (ovr_clr)       ovr_q <= 1'b0;
    end
  end

  always_comb begin
    reg_idx  = rd_addr[IDXW-1:0];
    reg_word = '0;
    if (reg_idx == '0)
      reg_word = W'({sel_q, done_q, ovr_q, irq_q});
    else if (reg_idx[IDXW-1:2] == (IDXW-2)'(1))
      reg_word = ts_q[0][W*reg_idx[1:0] +: W];
    else if (reg_idx[IDXW-1:2] == (IDXW-2)'(2))
      reg_word = ts_q[1][W*reg_idx[1:0] +: W];
  end

  always_ff @(posedge clk) begin
    if (store) mem[{bank_q, wptr_q}] <= samp_data;
    if (rd_addr[AW-1]) rd_q <= reg_word;
    else               rd_q <= mem[rd_addr[IDXW-1:0]];
  end

  assign rd_data    = rd_q;
  assign irq        = irq_q;
  assign active_sel = sel_q;

  // R5
  idle_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |-> (wptr_q == '0) && !bank_q && !irq_q);

  // R6
  bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_done |=> (bank_q != $past(bank_q)) && irq_q && (wptr_q == '0));

  // R7
  ts0_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_done && !bank_q |=> ts_q[0] == $past(tstamp));

  // R7
  ts1_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_done && bank_q |=> ts_q[1] == $past(tstamp));

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !irq_clr |=> irq_q);

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_done && irq_q |=> ovr_q);

  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running_q && !bank_done |=> $stable(sel_q));

endmodule

// File: rtl/adc_decim_capture.sv
module adc_decim_capture
  import adcch_pkg::*;
#(
  parameter int WORDS   = 256,
  parameter int DEC     = 8,
  parameter int NSTAGES = 2,
  parameter int TSW     = 64,
  localparam int W      = SAMPLE_W,
  localparam int SELW   = $clog2(NSTAGES + 1),
  localparam int AW     = $clog2(2 * WORDS) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_en,
  input  logic            ser_bit,
  input  logic            ser_sync,
  input  logic            trig,
  input  logic [SELW-1:0] rate_sel,
  input  logic [AW-1:0]   rd_addr,
  output logic [W-1:0]    rd_data,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [1:0]      wr_data,
  output logic            irq
);
  logic          st_v [NSTAGES+1];
  logic [W-1:0]  st_d [NSTAGES+1];
  logic [TSW-1:0] tstamp_q;
  logic [SELW-1:0] active_sel;
  logic          samp_v;
  logic [W-1:0]  samp_d;

  adcch_deser #(.W(W)) u_deser (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(ser_bit), .sync(ser_sync),
    .word_valid(st_v[0]), .word_data(st_d[0])
  );

  for (genvar s = 0; s < NSTAGES; s++) begin : g_stage
    adcch_decim #(.DEC(DEC), .W(W)) u_decim (
      .clk(clk), .rst_n(rst_n),
      .in_valid(st_v[s]), .in_data(st_d[s]),
      .out_valid(st_v[s+1]), .out_data(st_d[s+1])
    );
  end

  // Codes above the deepest stage clamp to it.
  always_comb begin
    int idx;
    idx    = (int'(active_sel) > NSTAGES) ? NSTAGES : int'(active_sel);
    samp_v = st_v[idx];
    samp_d = st_d[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tstamp_q <= '0;
    else        tstamp_q <= tstamp_q + 1'b1;
  end

  adcch_pingpong #(.WORDS(WORDS), .W(W), .TSW(TSW), .SELW(SELW), .AW(AW)) u_buf (
    .clk(clk), .rst_n(rst_n), .trig(trig), .rate_sel(rate_sel), .active_sel(active_sel),
    .samp_valid(samp_v), .samp_data(samp_d), .tstamp(tstamp_q),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
  );

  // R7
  tstamp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> tstamp_q == $past(tstamp_q) + 1'b1);

endmodule

// File: tb/adc_decim_capture_test.sv
module adc_decim_capture_test;
  localparam int N    = 16;
  localparam int AW   = $clog2(2 * N) + 1;
  localparam int RBASE = 2 * N;   // register space base

  logic clk = 1'b0;
  logic rst_n, bit_en, ser_bit, ser_sync, trig, wr_en;
  logic [1:0] rate_sel, wr_data;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [15:0] rd_data;
  logic irq;

  int nchk = 0, nerr = 0;
  bit done_flag = 0;

  logic [15:0] xs [1024];
  logic [15:0] d1 [128];
  logic [15:0] d2 [16];

  always #10 clk = ~clk;

  adc_decim_capture #(.WORDS(N)) uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_bit(ser_bit), .ser_sync(ser_sync),
    .trig(trig), .rate_sel(rate_sel), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] sel);
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; ser_bit = 1'b0; ser_sync = 1'b0; trig = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; rate_sel = sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [15:0] v);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      bit_en = 1'b1; ser_bit = v[i]; ser_sync = (i == 15);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    bit_en = 1'b0; ser_sync = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = AW'(a);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wr_ctl(input logic [1:0] bits);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(RBASE); wr_data = bits;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fill_pseudo();
    for (int i = 0; i < 1024; i++) xs[i] = 16'((i * 7919 + 12345) % 65536);
  endtask

  // Filter restated with paired symmetric taps.
  function automatic logic [15:0] ref_fir(input int a0, a1, a2, a3, a4, a5, a6, a7);
    int acc;
    acc = (a0 + a7) + 3 * (a1 + a6) + 5 * (a2 + a5) + 7 * (a3 + a4);
    acc = acc >>> 5;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return 16'(acc);
  endfunction

  function automatic int sx(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  task automatic build_model();
    for (int k = 0; k < 128; k++)
      d1[k] = ref_fir(sx(xs[8*k]), sx(xs[8*k+1]), sx(xs[8*k+2]), sx(xs[8*k+3]),
                      sx(xs[8*k+4]), sx(xs[8*k+5]), sx(xs[8*k+6]), sx(xs[8*k+7]));
    for (int k = 0; k < 16; k++)
      d2[k] = ref_fir(sx(d1[8*k]), sx(d1[8*k+1]), sx(d1[8*k+2]), sx(d1[8*k+3]),
                      sx(d1[8*k+4]), sx(d1[8*k+5]), sx(d1[8*k+6]), sx(d1[8*k+7]));
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset(2'd0);
    chk("R10 irq low after reset", 64'(irq), 64'd0);
    rd(RBASE, v);
    chk("R10 status zero after reset", 64'(v), 64'd0);
  endtask

  task automatic t_pretrig();
    logic [15:0] v;
    do_reset(2'd0);
    fill_pseudo();
    for (int i = 0; i < 5; i++) send(xs[i]);
    idle(4);
    rd(RBASE, v);
    chk("R5 no capture before trigger", 64'(v), 64'd0);
    trig = 1'b1;
    idle(2);
    for (int i = 5; i < 21; i++) send(xs[i]);
    idle(4);
    chk("R6 irq after one bank", 64'(irq), 64'd1);
    rd(0, v);  chk("R5 first stored is first after trigger", 64'(v), 64'(xs[5]));
    rd(15, v); chk("R5 last word of bank 0", 64'(v), 64'(xs[20]));
    rd(RBASE, v);
    chk("R6 status bank0 done", 64'(v), 64'd1);
    wr_ctl(2'b01);
    chk("R8 ack clears irq", 64'(irq), 64'd0);
    rd(RBASE, v);
    chk("R8 status after ack", 64'(v), 64'd0);
  endtask

  task automatic t_raw();
    logic [15:0] v;
    logic [63:0] t0, t1;
    do_reset(2'd0);
    fill_pseudo();
    trig = 1'b1;
    idle(2);
    for (int i = 0; i < 32; i++) send(xs[i]);
    idle(4);
    for (int i = 0; i < 32; i++) begin
      rd(i, v);
      chk($sformatf("R1 raw word %0d", i), 64'(v), 64'(xs[i]));
    end
    rd(RBASE, v);
    chk("R8 overrun with done bank 1", 64'(v), 64'd7);
    t0 = '0; t1 = '0;
    for (int w = 0; w < 4; w++) begin
      rd(RBASE + 4 + w, v); t0[16*w +: 16] = v;
      rd(RBASE + 8 + w, v); t1[16*w +: 16] = v;
    end
    chk("R7 timestamp spacing", t1 - t0, 64'd256);
    wr_ctl(2'b01);
    rd(RBASE, v);
    chk("R8 overrun kept after irq ack", 64'(v), 64'd6);
    chk("R8 irq low", 64'(irq), 64'd0);
    wr_ctl(2'b10);
    rd(RBASE, v);
    chk("R8 overrun cleared", 64'(v), 64'd4);
  endtask

  task automatic t_div8();
    logic [15:0] v;
    do_reset(2'd1);
    fill_pseudo();
    build_model();
    trig = 1'b1;
    idle(2);
    for (int i = 0; i < 128; i++) send(xs[i]);
    idle(8);
    for (int i = 0; i < 16; i++) begin
      rd(i, v);
      chk($sformatf("R2 div8 word %0d", i), 64'(v), 64'(d1[i]));
    end
    rd(RBASE, v);
    chk("R2 status div8", 64'(v), 64'd9);
  endtask

  task automatic t_dc();
    logic [15:0] v;
    do_reset(2'd1);
    for (int i = 0; i < 1024; i++) xs[i] = (i < 36) ? 16'h7FFF : 16'hB1E0;
    build_model();
    trig = 1'b1;
    idle(2);
    for (int i = 0; i < 64; i++) send(xs[i]);
    idle(8);
    rd(0, v); chk("R4 full scale passes", 64'(v), 64'h7FFF);
    rd(3, v); chk("R4 full scale block 3", 64'(v), 64'h7FFF);
    rd(4, v); chk("R4 mixed block", 64'(v), 64'(16'd6383));
    rd(5, v); chk("R4 negative constant passes", 64'(v), 64'hB1E0);
    rd(7, v); chk("R4 negative block 7", 64'(v), 64'(d1[7]));
  endtask

  task automatic t_div64();
    logic [15:0] v;
    do_reset(2'd2);
    fill_pseudo();
    build_model();
    trig = 1'b1;
    idle(2);
    for (int i = 0; i < 1024; i++) send(xs[i]);
    idle(8);
    for (int i = 0; i < 16; i++) begin
      rd(i, v);
      chk($sformatf("R3 div64 word %0d", i), 64'(v), 64'(d2[i]));
    end
    rd(RBASE, v);
    chk("R3 status div64", 64'(v), 64'd17);
  endtask

  task automatic t_ratechg();
    logic [15:0] v;
    do_reset(2'd0);
    fill_pseudo();
    build_model();
    trig = 1'b1;
    idle(2);
    for (int i = 0; i < 4; i++) send(xs[i]);
    rate_sel = 2'd1;
    for (int i = 4; i < 24; i++) send(xs[i]);
    idle(8);
    rd(4, v);  chk("R9 raw kept after change", 64'(v), 64'(xs[4]));
    rd(15, v); chk("R9 raw to bank end", 64'(v), 64'(xs[15]));
    rd(N, v);  chk("R9 next bank starts div8", 64'(v), 64'(d1[1]));
    rd(N + 1, v); chk("R9 next bank second word", 64'(v), 64'(d1[2]));
    rd(RBASE, v);
    chk("R9 status shows new rate", 64'(v), 64'd9);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_pretrig();
    t_raw();
    t_div8();
    t_dc();
    t_div64();
    t_ratechg();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

endmodule